// File: doc/BRIEF.md
# Counted Block Receiver with CRC-16

This block takes a command block one byte at a time from a session controller. The first byte gives the total block length. That length counts the length byte itself, the packet bytes and the two trailing checksum bytes. The receiver tracks the block against that length and runs a CRC-16 over the length byte and the packet bytes. When the last byte arrives, it compares the running CRC with the received checksum. A good block is handed to the command parser as a flat packet vector: opcode, first parameter, two-byte second parameter, then optional data. The handover is marked by a one-cycle strobe.

A length byte outside the legal window ends the block at once. A checksum mismatch also ends it. In both cases the block raises a one-cycle communications-error strobe and sets its result code to the value that selects the error status response. The session controller can abort a partial block at any time, for example on a timeout or a sleep request. A second, independent CRC accumulator uses the same arithmetic for the response blocks that leave the chip.

Top module: `cmd_block_rx`

## Requirements
- R1: After reset, `pkt_valid_o` and `comm_err_o` are 0, `result_code_o` is 8'h00, `tx_crc_o` is 16'h0000 and the receiver expects a length byte.
- R2: A length byte below 4 or above 39 raises `comm_err_o` for one cycle, starting the cycle after that byte is taken. The next byte is treated as a new length byte.
- R3: The CRC uses polynomial 16'h8005 with initial value 0. It covers the length byte and the packet bytes, and feeds each byte into the register least significant bit first. Per bit: feedback = data bit XOR crc[15], then crc shifts left by one and is XORed with 16'h8005 if feedback is 1.
- R4: The checksum arrives as two bytes, low byte first and high byte last. On a match, `pkt_valid_o` pulses for one cycle, starting the cycle after the high byte. `pkt_len_o` then equals length minus 3. Packet byte k (k=0 is the opcode, k=1 the first parameter, k=2..3 the second parameter) sits at `pkt_data_o[8k+7:8k]`, and unused bytes read 0.
- R5: On a checksum mismatch, `comm_err_o` pulses for one cycle, starting the cycle after the high byte, and `pkt_valid_o` stays 0.
- R6: `result_code_o` becomes 8'h00 with each accepted packet and 8'hFF with each communications error, and holds between them.
- R7: `abort_i` returns the receiver to expecting a length byte and drops any partial block. A byte presented in the same cycle as `abort_i` is discarded, and neither strobe fires in the following cycle.
- R8: Lengths of exactly 4 (one packet byte) and exactly 39 (36 packet bytes) are accepted.
- R9: The response CRC accumulator uses the arithmetic of R3 and updates one cycle after each `tx_valid_i` byte. `tx_clear_i` alone sets it to 0. `tx_clear_i` together with a byte restarts it from 0 with that byte.
- R10: `pkt_valid_o` and `comm_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort_i | input | 1 | Drop partial block (timeout or sleep) |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| pkt_valid_o | output | 1 | One-cycle strobe: good packet available |
| pkt_len_o | output | 6 | Packet byte count of last good block |
| pkt_data_o | output | 288 | Packet bytes, byte k at bits 8k+7:8k |
| comm_err_o | output | 1 | One-cycle strobe: bad length or bad checksum |
| result_code_o | output | 8 | 8'h00 after good packet, 8'hFF after error |
| tx_clear_i | input | 1 | Restart response CRC |
| tx_valid_i | input | 1 | Response byte strobe |
| tx_byte_i | input | 8 | Response byte |
| tx_crc_o | output | 16 | Running response CRC |

## Verification
Two functions can meet in one cycle: the controller's abort, and the acceptance of the final checksum byte that would otherwise raise a strobe. The bench drives `abort_i` and the high checksum byte of a valid block on the same clock edge. It then checks that neither strobe appears, and that the next byte is taken as a fresh length byte that completes a new block normally. A second case presents a response-CRC clear together with a data byte, and checks the restart value.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam logic [15:0] CRC_POLY = 16'h8005;

  typedef enum logic [1:0] {
    ST_COUNT,
    ST_BODY,
    ST_CK_LO,
    ST_CK_HI
  } rx_state_e;

  // One byte into the CRC register, least significant data bit first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                             input logic [7:0]  data);
    logic [15:0] r;
    r = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (data[i] ^ r[15]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else                 r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/cbr_crc_acc.sv
module cbr_crc_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import cbr_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crc_q <= '0;
    else if (clear_i && en_i)  crc_q <= crc16_byte(16'h0000, byte_i);
    else if (clear_i)          crc_q <= '0;
    else if (en_i)             crc_q <= crc16_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !en_i) |=> (crc_o == 16'h0000));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !en_i) |=> $stable(crc_o));

endmodule

// File: rtl/cbr_framer.sv
module cbr_framer #(
  parameter int MAX_BLK = 39,
  parameter int MIN_BLK = 4,
  localparam int LEN_W  = $clog2(MAX_BLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  input  logic [15:0]      crc_i,
  output logic             crc_clr_o,
  output logic             crc_en_o,
  output logic             buf_clr_o,
  output logic             wr_en_o,
  output logic [LEN_W-1:0] wr_idx_o,
  output logic             pkt_valid_o,
  output logic [LEN_W-1:0] pkt_len_o,
  output logic             comm_err_o,
  output logic [7:0]       code_o
);
  import cbr_pkg::*;

  localparam int OVERHEAD = 3;

  rx_state_e        state_q;
  logic [LEN_W-1:0] plen_q, pos_q;
  logic [7:0]       ck_lo_q;

  // Named internal events
  logic take, cnt_take, count_ok, body_take, last_body, ck_match;

  assign take      = valid_i && !abort_i;
  assign cnt_take  = take && (state_q == ST_COUNT);
  assign body_take = take && (state_q == ST_BODY);
  assign count_ok  = (byte_i >= 8'(MIN_BLK)) && (byte_i <= 8'(MAX_BLK));
  assign last_body = (pos_q == plen_q - LEN_W'(1));
  assign ck_match  = ({byte_i, ck_lo_q} == crc_i);

  assign crc_clr_o = abort_i || cnt_take;
  assign crc_en_o  = cnt_take || body_take;
  assign buf_clr_o = abort_i || (cnt_take && count_ok);
  assign wr_en_o   = body_take;
  assign wr_idx_o  = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_COUNT;
      plen_q      <= '0;
      pos_q       <= '0;
      ck_lo_q     <= '0;
      pkt_valid_o <= 1'b0;
      pkt_len_o   <= '0;
      comm_err_o  <= 1'b0;
      code_o      <= 8'h00;
    end else if (abort_i) begin
      state_q     <= ST_COUNT;
      pos_q       <= '0;
      ck_lo_q     <= '0;
      pkt_valid_o <= 1'b0;
      comm_err_o  <= 1'b0;
    end else begin
      pkt_valid_o <= 1'b0;
      comm_err_o  <= 1'b0;
      if (take) begin
        unique case (state_q)
          ST_COUNT: begin
            if (count_ok) begin
              plen_q  <= LEN_W'(byte_i) - LEN_W'(OVERHEAD);
              pos_q   <= '0;
              state_q <= ST_BODY;
            end else begin
              comm_err_o <= 1'b1;
              code_o     <= 8'hFF;
            end
          end
          ST_BODY: begin
            pos_q <= pos_q + LEN_W'(1);
            if (last_body) state_q <= ST_CK_LO;
          end
          ST_CK_LO: begin
            ck_lo_q <= byte_i;
            state_q <= ST_CK_HI;
          end
          ST_CK_HI: begin
            state_q <= ST_COUNT;
            if (ck_match) begin
              pkt_valid_o <= 1'b1;
              pkt_len_o   <= plen_q;
              code_o      <= 8'h00;
            end else begin
              comm_err_o <= 1'b1;
              code_o     <= 8'hFF;
            end
          end
          default: state_q <= ST_COUNT;
        endcase
      end
    end
  end

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid_o && comm_err_o));

  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!pkt_valid_o && !comm_err_o));

  // R2
  bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_take && !count_ok) |=> (comm_err_o && state_q == ST_COUNT));

  // R6
  code_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (code_o == 8'h00));

  // R6
  code_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comm_err_o |-> (code_o == 8'hFF));

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (pkt_len_o >= LEN_W'(MIN_BLK - OVERHEAD) &&
                     pkt_len_o <= LEN_W'(MAX_BLK - OVERHEAD)));

  // R5
  pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o || comm_err_o) |=> (state_q == ST_COUNT || state_q == ST_BODY));

endmodule

// File: rtl/cbr_pkt_buf.sv
module cbr_pkt_buf #(
  parameter int MAX_PKT = 36,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_byte_i,
  output logic [MAX_PKT*8-1:0] data_o
);

  for (genvar k = 0; k < MAX_PKT; k++) begin : g_byte
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q <= '0;
      else if (clr_i)                              slot_q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(k))   slot_q <= wr_byte_i;
    end
    assign data_o[8*k +: 8] = slot_q;
  end

endmodule

// File: rtl/cmd_block_rx.sv
module cmd_block_rx #(
  parameter int  MAX_BLK = 39,
  parameter int  MIN_BLK = 4,
  localparam int MAX_PKT = MAX_BLK - 3,
  localparam int LEN_W   = $clog2(MAX_BLK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abort_i,
  input  logic                 rx_valid_i,
  input  logic [7:0]           rx_byte_i,
  output logic                 pkt_valid_o,
  output logic [LEN_W-1:0]     pkt_len_o,
  output logic [MAX_PKT*8-1:0] pkt_data_o,
  output logic                 comm_err_o,
  output logic [7:0]           result_code_o,
  input  logic                 tx_clear_i,
  input  logic                 tx_valid_i,
  input  logic [7:0]           tx_byte_i,
  output logic [15:0]          tx_crc_o
);

  logic [15:0]      rx_crc;
  logic             crc_clr, crc_en, buf_clr, wr_en;
  logic [LEN_W-1:0] wr_idx;

  cbr_framer #(.MAX_BLK(MAX_BLK), .MIN_BLK(MIN_BLK)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort_i     (abort_i),
    .valid_i     (rx_valid_i),
    .byte_i      (rx_byte_i),
    .crc_i       (rx_crc),
    .crc_clr_o   (crc_clr),
    .crc_en_o    (crc_en),
    .buf_clr_o   (buf_clr),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .pkt_valid_o (pkt_valid_o),
    .pkt_len_o   (pkt_len_o),
    .comm_err_o  (comm_err_o),
    .code_o      (result_code_o)
  );

  cbr_crc_acc u_rx_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (crc_clr),
    .en_i    (crc_en),
    .byte_i  (rx_byte_i),
    .crc_o   (rx_crc)
  );

  cbr_pkt_buf #(.MAX_PKT(MAX_PKT), .IDX_W(LEN_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (buf_clr),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_byte_i (rx_byte_i),
    .data_o    (pkt_data_o)
  );

  cbr_crc_acc u_tx_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (tx_clear_i),
    .en_i    (tx_valid_i),
    .byte_i  (tx_byte_i),
    .crc_o   (tx_crc_o)
  );

  // R4
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid_i && !abort_i) |=> $stable(pkt_data_o));

endmodule

// File: tb/cmd_block_rx_tb_top.sv
module cmd_block_rx_tb_top;

  localparam int MAX_BLK = 39;
  localparam int MAX_PKT = MAX_BLK - 3;
  localparam int DW      = MAX_PKT * 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           abort_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0]     rx_byte_i = '0;
  logic           pkt_valid_o, comm_err_o;
  logic [5:0]     pkt_len_o;
  logic [DW-1:0]  pkt_data_o;
  logic [7:0]     result_code_o;
  logic           tx_clear_i = 1'b0, tx_valid_i = 1'b0;
  logic [7:0]     tx_byte_i = '0;
  logic [15:0]    tx_crc_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]    blk [0:63];
  logic [DW-1:0] exp_data;
  int            blk_n;

  always #10 clk = ~clk;

  cmd_block_rx dut_i (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
    .pkt_valid_o(pkt_valid_o), .pkt_len_o(pkt_len_o), .pkt_data_o(pkt_data_o),
    .comm_err_o(comm_err_o), .result_code_o(result_code_o),
    .tx_clear_i(tx_clear_i), .tx_valid_i(tx_valid_i), .tx_byte_i(tx_byte_i),
    .tx_crc_o(tx_crc_o)
  );

  // Reference CRC written as a masked shift (R3)
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = d[i] ^ r[15];
      r = {r[14:0], 1'b0} ^ ({16{fb}} & 16'h8005);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit ab);
    @(negedge clk);
    rx_valid_i = 1'b1; rx_byte_i = b; abort_i = ab;
    @(negedge clk);
    rx_valid_i = 1'b0; abort_i = 1'b0;
  endtask

  // Build a block of total length cnt with packet bytes seed + 7k
  task automatic build(input int cnt, input logic [7:0] seed);
    logic [15:0] c;
    blk_n = cnt;
    exp_data = '0;
    blk[0] = 8'(cnt);
    c = ref_crc(16'h0000, blk[0]);
    for (int k = 0; k < cnt - 3; k++) begin
      blk[k+1] = seed + 8'(7 * k);
      exp_data[8*k +: 8] = blk[k+1];
      c = ref_crc(c, blk[k+1]);
    end
    blk[cnt-2] = c[7:0];
    blk[cnt-1] = c[15:8];
  endtask

  task automatic send_all();
    for (int k = 0; k < blk_n; k++) put(blk[k], 1'b0);
  endtask

  task automatic expect_good(input string tag);
    chk(pkt_valid_o === 1'b1, {tag, " pkt_valid"}, DW'(pkt_valid_o), DW'(1));
    chk(comm_err_o === 1'b0, {tag, " comm_err low R10"}, DW'(comm_err_o), DW'(0));
    chk(pkt_len_o == 6'(blk_n - 3), {tag, " pkt_len"}, DW'(pkt_len_o), DW'(blk_n - 3));
    chk(pkt_data_o == exp_data, {tag, " pkt_data"}, pkt_data_o, exp_data);
    chk(result_code_o == 8'h00, {tag, " code R6"}, DW'(result_code_o), DW'(8'h00));
    @(negedge clk);
    chk(pkt_valid_o === 1'b0, {tag, " single pulse"}, DW'(pkt_valid_o), DW'(0));
  endtask

  task automatic expect_err(input string tag);
    chk(comm_err_o === 1'b1, {tag, " comm_err"}, DW'(comm_err_o), DW'(1));
    chk(pkt_valid_o === 1'b0, {tag, " no pkt R10"}, DW'(pkt_valid_o), DW'(0));
    chk(result_code_o == 8'hFF, {tag, " code R6"}, DW'(result_code_o), DW'(8'hFF));
    @(negedge clk);
    chk(comm_err_o === 1'b0, {tag, " single pulse"}, DW'(comm_err_o), DW'(0));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_valid_o === 1'b0 && comm_err_o === 1'b0, "R1 strobes", DW'({pkt_valid_o, comm_err_o}), DW'(0));
    chk(result_code_o === 8'h00, "R1 code", DW'(result_code_o), DW'(0));
    chk(tx_crc_o === 16'h0000, "R1 tx_crc", DW'(tx_crc_o), DW'(0));
  endtask

  task automatic t_typical();
    build(7, 8'h41); send_all(); expect_good("R3 R4 len7");
    build(12, 8'hC3); send_all(); expect_good("R3 R4 len12");
  endtask

  task automatic t_bounds();
    build(4, 8'h5A); send_all(); expect_good("R8 min4");
    build(39, 8'h09); send_all(); expect_good("R8 max39");
  endtask

  task automatic t_bad_count();
    put(8'd3, 1'b0);  expect_err("R2 count3");
    build(5, 8'h10); send_all(); expect_good("R2 recover after 3");
    put(8'd40, 1'b0); expect_err("R2 count40");
    put(8'd0, 1'b0);  expect_err("R2 count0");
    build(6, 8'h22); send_all(); expect_good("R2 recover after 40");
  endtask

  task automatic t_bad_crc();
    build(8, 8'h31);
    blk[blk_n-1] = blk[blk_n-1] ^ 8'h01;
    send_all(); expect_err("R5 bad hi");
    build(8, 8'h31);
    {blk[blk_n-2], blk[blk_n-1]} = {blk[blk_n-1], blk[blk_n-2]};
    if (blk[blk_n-2] != blk[blk_n-1]) begin
      send_all(); expect_err("R4 R5 swapped order");
    end
  endtask

  task automatic t_abort_mid();
    build(10, 8'h77);
    for (int k = 0; k < 5; k++) put(blk[k], 1'b0);
    @(negedge clk); abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    chk(pkt_valid_o === 1'b0 && comm_err_o === 1'b0, "R7 abort quiet", DW'({pkt_valid_o, comm_err_o}), DW'(0));
    chk(pkt_data_o == '0, "R7 abort clears partial", pkt_data_o, '0);
    build(6, 8'h88); send_all(); expect_good("R7 after abort");
  endtask

  task automatic t_abort_collide();
    build(9, 8'h19);
    for (int k = 0; k < blk_n - 1; k++) put(blk[k], 1'b0);
    put(blk[blk_n-1], 1'b1);
    chk(pkt_valid_o === 1'b0 && comm_err_o === 1'b0, "R7 collide no strobe", DW'({pkt_valid_o, comm_err_o}), DW'(0));
    build(5, 8'hA0); send_all(); expect_good("R7 collide restart");
  endtask

  task automatic t_tx_crc();
    logic [15:0] e;
    @(negedge clk); tx_clear_i = 1'b1; @(negedge clk); tx_clear_i = 1'b0;
    chk(tx_crc_o === 16'h0000, "R9 clear", DW'(tx_crc_o), DW'(0));
    e = ref_crc(ref_crc(16'h0000, 8'h04), 8'hFF);
    @(negedge clk); tx_valid_i = 1'b1; tx_byte_i = 8'h04;
    @(negedge clk); tx_byte_i = 8'hFF;
    @(negedge clk); tx_valid_i = 1'b0;
    chk(tx_crc_o === e, "R9 status block crc", DW'(tx_crc_o), DW'(e));
    @(negedge clk);
    chk(tx_crc_o === e, "R9 hold", DW'(tx_crc_o), DW'(e));
    e = ref_crc(16'h0000, 8'h0F);
    tx_clear_i = 1'b1; tx_valid_i = 1'b1; tx_byte_i = 8'h0F;
    @(negedge clk); tx_clear_i = 1'b0; tx_valid_i = 1'b0;
    chk(tx_crc_o === e, "R9 clear with byte", DW'(tx_crc_o), DW'(e));
  endtask

  initial begin
    t_reset();
    t_typical();
    t_bounds();
    t_bad_count();
    t_bad_crc();
    t_abort_mid();
    t_abort_collide();
    t_tx_crc();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule